// File: doc/BRIEF.md
# Stereo PWM Audio Output Stage

This block turns a stream of signed stereo PCM sample pairs into differential P/N pad levels for a class-D style speaker driver. A free-running period counter of 2^SAMPLE_W clock cycles sets the PWM frame. At the last count of each frame the block takes one left/right pair from a valid/ready input. That pair then sets the pulse widths for the whole next frame. If no pair is offered at that moment, the previous pair is played again.

Several static controls shape the output:
- A mono switch copies the left sample onto the right channel.
- Each channel has its own enable.
- A sign-remapped mode pulses only one leg of a channel, chosen by the sample's sign.
- A global invert flips both pad legs just before the pads.
- An idle-run mode keeps the input consuming samples at the normal rate while the pads hold a programmed static pattern. The same pattern drives the pads whenever the block is stopped or a channel is disabled.

A run input starts the counter. A one-cycle soft-reset request restarts the frame and clears the held samples and pads, and it needs no separate release.

Top module: `stereo_pwm_driver`

## Requirements
- R1: After the asynchronous reset (rstN low), padP, padN and padOe are all 0 and inReady is 0 while runEn is 0.
- R2: inReady is 1 only in the last cycle of each 2^SAMPLE_W-cycle frame while runEn is 1 and softRst is 0. The frame counter holds at its last value while runEn is 0, so the first running cycle is a boundary.
- R3: A pair is captured only when inValid and inReady are both 1. With no valid pair at a boundary, the held pair is reused for the next frame.
- R4: In normal modulation, a channel is active when runEn=1, idleRun=0 and its enable=1. In the cycle after counter value c, P is 1 exactly when c < sample + 2^(SAMPLE_W-1), N is the complement of P, and padOe is 1.
- R5: With remapMode=1 on an active channel, a positive sample s gives P=1 when c < s and N=0. A negative sample gives N=1 when c < -s and P=0. A zero sample gives P=N=0.
- R6: With monoMode=1, the right channel is computed from the held left sample.
- R7: A channel whose enable is 0 shows the idle pattern rather than PWM. The other channel is unaffected.
- R8: The idle pattern is set by idleLevel. Code 0 gives P=0, N=0 with OE=1. Code 1 gives P=1, N=1 with OE=1. Code 2 gives P=1, N=0 with OE=1. Code 3 gives OE=0 with P=N=0. The pattern applies on both channels whenever runEn=0.
- R9: With idleRun=1 and runEn=1, both channels show the idle pattern while inReady and sample capture continue exactly as in R2 and R3.
- R10: invertAll=1 inverts padP and padN (PWM and idle pattern alike) but never padOe.
- R11: softRst=1 for one cycle clears padP/padN/padOe to 0 on the next edge. The held samples become 0 and the frame counter returns to its last value, so the next running cycle is a boundary.
- R12: Each pad output is registered: it reflects the counter, held samples and controls of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Run: counter advances, samples accepted |
| softRst | input | 1 | One-cycle restart request |
| monoMode | input | 1 | Right channel follows left sample |
| leftEn | input | 1 | Left channel enable |
| rightEn | input | 1 | Right channel enable |
| remapMode | input | 1 | Sign-remapped modulation |
| invertAll | input | 1 | Invert P and N pad levels |
| idleRun | input | 1 | Consume samples, pads show idle pattern |
| idleLevel | input | 2 | Idle pattern code (see R8) |
| inValid | input | 1 | Sample pair valid |
| inReady | output | 1 | Pair accepted this cycle (frame boundary) |
| inLeft | input | SAMPLE_W | Signed left sample |
| inRight | input | SAMPLE_W | Signed right sample |
| padP | output | 2 | P pad level, bit 0 left, bit 1 right |
| padN | output | 2 | N pad level, bit 0 left, bit 1 right |
| padOe | output | 2 | Pad output enable per channel |

## Verification
The bench drives the extreme samples: the most negative code, which in remap mode must give a full half-frame N pulse, the most positive code, and zero, which in remap mode must leave both legs low. A design that took the magnitude wrongly or picked the wrong leg would show a pulse on the silent leg or a wrong width. Starved boundaries test that the old pair is replayed; a design that latched the bus data without valid would play whatever sat on the bus. Idle-run is checked to keep inReady pulsing once per frame while the pads stay fixed. Soft reset is pulsed mid-frame, where a design that only cleared the pads would keep the old count and the old samples.

// File: rtl/pwm_drv_pkg.sv
package pwm_drv_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture input pair this cycle
    logic clear;    // restart request
    logic running;  // run enable
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    IDLE_ALL_LOW  = 2'd0,
    IDLE_ALL_HIGH = 2'd1,
    IDLE_P_HI     = 2'd2,
    IDLE_OFF      = 2'd3
  } idleLvl_e;

  // Returns {oe, p, n} for an idle code
  function automatic logic [2:0] idlePattern(input logic [1:0] lvl);
    case (idleLvl_e'(lvl))
      IDLE_ALL_LOW:  return 3'b100;
      IDLE_ALL_HIGH: return 3'b111;
      IDLE_P_HI:     return 3'b110;
      default:       return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/pwm_drv_ctrl.sv
module pwm_drv_ctrl
  import pwm_drv_pkg::*;
#(
  parameter int SAMPLE_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                runEn,
  input  logic                softRst,
  input  logic                inValid,
  output logic                inReady,
  output logic [SAMPLE_W-1:0] cnt,
  output ctlStrobe_t          strobe
);
  localparam logic [SAMPLE_W-1:0] CntLast = {SAMPLE_W{1'b1}};

  logic atBoundary;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  cnt <= CntLast;
    else if (softRst || !runEn) cnt <= CntLast;
    else                        cnt <= cnt + 1'b1;
  end

  assign atBoundary = runEn && !softRst && (cnt == CntLast);
  assign inReady    = atBoundary;

  always_comb begin
    strobe.load    = atBoundary && inValid;
    strobe.clear   = softRst;
    strobe.running = runEn;
  end
endmodule

// File: rtl/pwm_drv_dp.sv
module pwm_drv_dp
  import pwm_drv_pkg::*;
#(
  parameter int SAMPLE_W = 6,
  parameter int NUM_CH   = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobe_t                 strobe,
  input  logic [SAMPLE_W-1:0]        cnt,
  input  logic signed [SAMPLE_W-1:0] inLeft,
  input  logic signed [SAMPLE_W-1:0] inRight,
  input  logic                       monoMode,
  input  logic [NUM_CH-1:0]          chanEn,
  input  logic                       remapMode,
  input  logic                       invertAll,
  input  logic                       idleRun,
  input  logic [1:0]                 idleLevel,
  output logic [NUM_CH-1:0]          padP,
  output logic [NUM_CH-1:0]          padN,
  output logic [NUM_CH-1:0]          padOe
);
  logic signed [SAMPLE_W-1:0] heldL, heldR;
  logic [NUM_CH-1:0] nextP, nextN, nextOe;
  logic [2:0] idl;

  assign idl = idlePattern(idleLevel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldL <= '0;
      heldR <= '0;
    end else if (strobe.clear) begin
      heldL <= '0;
      heldR <= '0;
    end else if (strobe.load) begin
      heldL <= inLeft;
      heldR <= inRight;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic signed [SAMPLE_W-1:0] smp;
    logic [SAMPLE_W-1:0] duty, mag;
    logic pwmP, pwmN, actv;

    assign smp  = (ch == 0 || monoMode) ? heldL : heldR;
    // offset-binary duty: sample + half scale
    assign duty = {~smp[SAMPLE_W-1], smp[SAMPLE_W-2:0]};
    assign mag  = smp[SAMPLE_W-1] ? ((~$unsigned(smp)) + 1'b1) : $unsigned(smp);
    assign actv = strobe.running && !idleRun && chanEn[ch];

    always_comb begin
      if (remapMode) begin
        pwmP = !smp[SAMPLE_W-1] && (cnt < mag);
        pwmN =  smp[SAMPLE_W-1] && (cnt < mag);
      end else begin
        pwmP = (cnt < duty);
        pwmN = !(cnt < duty);
      end
    end

    assign nextOe[ch] = actv ? 1'b1 : idl[2];
    assign nextP[ch]  = (actv ? pwmP : idl[1]) ^ invertAll;
    assign nextN[ch]  = (actv ? pwmN : idl[0]) ^ invertAll;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      padP  <= '0;
      padN  <= '0;
      padOe <= '0;
    end else if (strobe.clear) begin
      padP  <= '0;
      padN  <= '0;
      padOe <= '0;
    end else begin
      padP  <= nextP;
      padN  <= nextN;
      padOe <= nextOe;
    end
  end
endmodule

// File: rtl/stereo_pwm_driver.sv
module stereo_pwm_driver
  import pwm_drv_pkg::*;
#(
  parameter int SAMPLE_W = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       runEn,
  input  logic                       softRst,
  input  logic                       monoMode,
  input  logic                       leftEn,
  input  logic                       rightEn,
  input  logic                       remapMode,
  input  logic                       invertAll,
  input  logic                       idleRun,
  input  logic [1:0]                 idleLevel,
  input  logic                       inValid,
  output logic                       inReady,
  input  logic signed [SAMPLE_W-1:0] inLeft,
  input  logic signed [SAMPLE_W-1:0] inRight,
  output logic [1:0]                 padP,
  output logic [1:0]                 padN,
  output logic [1:0]                 padOe
);
  ctlStrobe_t          strobe;
  logic [SAMPLE_W-1:0] cnt;

  pwm_drv_ctrl #(.SAMPLE_W(SAMPLE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .softRst(softRst),
    .inValid(inValid), .inReady(inReady), .cnt(cnt), .strobe(strobe)
  );

  pwm_drv_dp #(.SAMPLE_W(SAMPLE_W), .NUM_CH(2)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cnt(cnt),
    .inLeft(inLeft), .inRight(inRight), .monoMode(monoMode),
    .chanEn({rightEn, leftEn}), .remapMode(remapMode),
    .invertAll(invertAll), .idleRun(idleRun), .idleLevel(idleLevel),
    .padP(padP), .padN(padN), .padOe(padOe)
  );
endmodule

// File: rtl/pwm_drv_chk.sv
module pwm_drv_chk (
  input logic       clk,
  input logic       rstN,
  input logic       runEn,
  input logic       softRst,
  input logic       leftEn,
  input logic       remapMode,
  input logic       invertAll,
  input logic       idleRun,
  input logic [1:0] idleLevel,
  input logic       inReady,
  input logic [1:0] padP,
  input logic [1:0] padN,
  input logic [1:0] padOe
);
  // R2
  ready_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |=> !inReady);

  // R4
  normal_complement_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !idleRun && !remapMode && leftEn && !softRst)
      |=> (padP[0] != padN[0]) && padOe[0]);

  // R5
  remap_one_leg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !idleRun && remapMode && !invertAll && leftEn && !softRst)
      |=> !(padP[0] && padN[0]));

  // R8
  stopped_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !softRst && idleLevel == 2'd3) |=> padOe == 2'b00);

  // R9
  idle_run_pattern_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && idleRun && idleLevel == 2'd2 && !invertAll && !softRst)
      |=> padP == 2'b11 && padN == 2'b00 && padOe == 2'b11);

  // R11
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> padP == 2'b00 && padN == 2'b00 && padOe == 2'b00);
endmodule

bind stereo_pwm_driver pwm_drv_chk u_chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .softRst(softRst),
  .leftEn(leftEn), .remapMode(remapMode), .invertAll(invertAll),
  .idleRun(idleRun), .idleLevel(idleLevel), .inReady(inReady),
  .padP(padP), .padN(padN), .padOe(padOe)
);

// File: tb/test_stereo_pwm_driver.sv
module test_stereo_pwm_driver;
  localparam int W    = 6;
  localparam int PER  = 1 << W;
  localparam int HALF = PER / 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic rstN = 1'b0, runEn = 1'b0, softRst = 1'b0, monoMode = 1'b0;
  logic leftEn = 1'b0, rightEn = 1'b0, remapMode = 1'b0, invertAll = 1'b0;
  logic idleRun = 1'b0, inValid = 1'b0;
  logic [1:0] idleLevel = 2'd0;
  logic signed [W-1:0] inLeft = '0, inRight = '0;
  logic inReady;
  logic [1:0] padP, padN, padOe;

  stereo_pwm_driver #(.SAMPLE_W(W)) i_stereo_pwm_driver (
    .clk(clk), .rstN(rstN), .runEn(runEn), .softRst(softRst),
    .monoMode(monoMode), .leftEn(leftEn), .rightEn(rightEn),
    .remapMode(remapMode), .invertAll(invertAll), .idleRun(idleRun),
    .idleLevel(idleLevel), .inValid(inValid), .inReady(inReady),
    .inLeft(inLeft), .inRight(inRight),
    .padP(padP), .padN(padN), .padOe(padOe)
  );

  int nRun = 0, nFail = 0, cyc = 0;
  string tag = "R1";
  bit rndData = 1'b1;

  // reference model state
  int mCnt = PER - 1, mL = 0, mR = 0;
  logic [1:0] eP = '0, eN = '0, eOe = '0;

  always @(posedge clk) begin
    if (!rstN || softRst) begin
      mCnt = PER - 1; mL = 0; mR = 0;
      eP = '0; eN = '0; eOe = '0;
    end else begin
      for (int ch = 0; ch < 2; ch++) begin
        int s;
        bit act, p, n, oe;
        s   = (ch == 0 || monoMode) ? mL : mR;
        act = runEn && !idleRun && ((ch == 0) ? leftEn : rightEn);
        if (act) begin
          oe = 1'b1;
          if (remapMode) begin
            p = (s > 0) && (mCnt < s);
            n = (s < 0) && (mCnt < -s);
          end else begin
            p = mCnt < s + HALF;
            n = !p;
          end
        end else begin
          case (idleLevel)
            2'd0: begin oe = 1; p = 0; n = 0; end
            2'd1: begin oe = 1; p = 1; n = 1; end
            2'd2: begin oe = 1; p = 1; n = 0; end
            default: begin oe = 0; p = 0; n = 0; end
          endcase
        end
        eP[ch]  = p ^ invertAll;
        eN[ch]  = n ^ invertAll;
        eOe[ch] = oe;
      end
      if (runEn && mCnt == PER - 1 && inValid) begin
        mL = int'(inLeft);
        mR = int'(inRight);
      end
      mCnt = runEn ? (mCnt + 1) % PER : PER - 1;
    end
  end

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  always @(negedge clk) begin
    logic eRdy;
    #1;
    eRdy = runEn && !softRst && (mCnt == PER - 1);
    nRun++;
    if ({padP, padN, padOe} !== {eP, eN, eOe} || inReady !== eRdy) begin
      nFail++;
      $display("FAIL %s (ready: R2) cyc %0d: actual P=%b N=%b OE=%b RDY=%b expected P=%b N=%b OE=%b RDY=%b",
               tag, cyc, padP, padN, padOe, inReady, eP, eN, eOe, eRdy);
    end
    cyc++;
    if (cyc > 150000) begin
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
      finishRun();
    end
  end

  task automatic cycles(int n, string t);
    tag = t;
    repeat (n) begin
      @(negedge clk);
      if (rndData) begin
        inLeft  = W'($urandom_range(0, PER - 1));
        inRight = W'($urandom_range(0, PER - 1));
      end
    end
  endtask

  task automatic fixedPair(int l, int r, int n, string t);
    @(negedge clk);
    rndData = 1'b0;
    inLeft  = W'(l);
    inRight = W'(r);
    cycles(n, t);
    rndData = 1'b1;
  endtask

  initial begin
    cycles(4, "R1");
    @(negedge clk); rstN = 1'b1;
    for (int lv = 0; lv < 4; lv++) begin
      idleLevel = 2'(lv);
      cycles(3, "R8");
    end
    // R4 / R12 normal modulation with random and extreme samples
    leftEn = 1; rightEn = 1; inValid = 1; runEn = 1;
    cycles(3 * PER, "R4");
    fixedPair(-HALF, HALF - 1, PER + 2, "R4");
    fixedPair(0, -1, PER, "R12");
    // R3 starvation: previous pair repeats
    inValid = 0;
    cycles(2 * PER, "R3");
    inValid = 1;
    // R5 remap
    remapMode = 1;
    fixedPair(-HALF, 0, PER, "R5");
    fixedPair(5, -1, PER, "R5");
    fixedPair(HALF - 1, -7, PER, "R5");
    cycles(3 * PER, "R5");
    remapMode = 0;
    // R6 mono
    monoMode = 1;
    cycles(2 * PER, "R6");
    remapMode = 1;
    cycles(PER, "R6");
    remapMode = 0; monoMode = 0;
    // R7 per-channel enable
    leftEn = 0; idleLevel = 2'd1;
    cycles(PER, "R7");
    idleLevel = 2'd2;
    cycles(PER / 2, "R7");
    leftEn = 1; rightEn = 0; idleLevel = 2'd3;
    cycles(PER, "R7");
    rightEn = 1;
    // R9 idle-run keeps consuming
    idleRun = 1;
    for (int lv = 0; lv < 4; lv++) begin
      idleLevel = 2'(lv);
      cycles(PER / 2 + 7, "R9");
    end
    idleRun = 0;
    cycles(PER, "R9");
    // R10 inversion
    invertAll = 1;
    cycles(2 * PER, "R10");
    idleRun = 1; idleLevel = 2'd2;
    cycles(PER / 2, "R10");
    idleRun = 0; runEn = 0; idleLevel = 2'd3;
    cycles(8, "R10");
    idleLevel = 2'd0;
    cycles(4, "R10");
    runEn = 1; invertAll = 0;
    // R11 soft reset mid-frame and with run off
    cycles(PER + 20, "R11");
    softRst = 1;
    cycles(1, "R11");
    softRst = 0;
    cycles(2 * PER, "R11");
    runEn = 0; softRst = 1;
    cycles(1, "R11");
    softRst = 0;
    cycles(4, "R11");
    runEn = 1;
    cycles(PER, "R11");
    finishRun();
  end
endmodule